// File: doc/BRIEF.md
# Windowed Watchdog Timer with Keyed Refresh

This block supervises software through an up-counting watchdog. The counter advances on a watchdog tick. The tick comes from a selectable source: either a slow oscillator pulse or every bus clock cycle. That source then passes through a programmable divider that divides by one to eight. Software keeps the system alive by writing a two-word key to the refresh register. The first word arms the sequencer and the second word clears the counter. A second word that does not match is treated as a deliberate request and resets the system at once.

When the counter reaches the programmed timeout, the block issues a one-cycle reset request. If the interrupt is enabled, it first sets a sticky flag and pulses an interrupt. It then waits a fixed grace period, counted in watchdog ticks, before it requests the reset. In window mode, a correct key that arrives while the counter is still below the window value is a fault and also causes a reset.

Separate run bits decide whether counting continues while the processor is halted for debug, stopped or waiting. A saturating counter records how many resets the watchdog has caused. That counter survives watchdog resets and is cleared only by power-on reset or by a dedicated clear word.

Top module: `wdt_window_core`

## Requirements
- R1: With `cfg_enable` high, a bus write of 0xA602 to select 0 (`bus_sel`=0), followed by a write of 0xB480 to the same select, clears `count_o` to 0 at the clock edge of the second write.
- R2: If the sequencer is armed by 0xA602 and the next select-0 write is any value other than 0xB480, `wdog_rst_o` is high in the cycle after that write. A select-0 write of any value other than 0xA602 while the sequencer is idle has no effect.
- R3: With the interrupt disabled and the bus-clock source, `wdog_rst_o` rises exactly T*(P+1) cycles after the refreshing edge. T is `cfg_timeout` and P is `cfg_presc`.
- R4: A prescaler code P gives one watchdog tick every P+1 source ticks.
- R5: When `cfg_src_bus`=1, every clock cycle is a source tick. When `cfg_src_bus`=0, only cycles with `lpo_tick` high are source ticks.
- R6: With `cfg_irq_en`=1, a timeout sets `flag_o` and gives a one-cycle `irq_o` pulse. `wdog_rst_o` follows GRACE_TICKS (128) watchdog ticks later, and refresh keys do not cancel it.
- R7: Writing select 1 with `bus_wdata[0]`=1 clears `flag_o`. Writing 0 in that bit leaves the flag unchanged, and a new flag set takes priority over a clear in the same cycle.
- R8: With `cfg_win_en`=1, a correct key that completes while `count_o` < `cfg_window` causes a reset. A correct key that completes at or above the window value is a normal refresh.
- R9: While `cpu_debug`, `cpu_stop` or `cpu_wait` is high and the matching run bit is 0, `count_o` holds its value. When the run bit is 1, counting continues.
- R10: `rst_count_o` increments once per watchdog reset and saturates at 0xFFFF. A select-2 write of 0xFFFF clears it, and a select-2 write of any other value has no effect.
- R11: After `rst_n`, all outputs are 0. A watchdog reset clears the counter and the key sequencer but keeps `rst_count_o`.
- R12: With `cfg_enable`=0, the counter does not advance and key writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low power-on reset |
| cfg_enable | input | 1 | Watchdog enable |
| cfg_src_bus | input | 1 | Source select: 1 bus clock, 0 slow oscillator pulses |
| cfg_presc | input | 3 | Divider code, divide by code+1 |
| cfg_irq_en | input | 1 | Interrupt before reset |
| cfg_win_en | input | 1 | Window mode |
| cfg_run_debug | input | 1 | Keep counting in debug halt |
| cfg_run_stop | input | 1 | Keep counting in stop mode |
| cfg_run_wait | input | 1 | Keep counting in wait mode |
| cfg_timeout | input | 32 | Timeout value in watchdog ticks |
| cfg_window | input | 32 | Earliest allowed refresh count |
| lpo_tick | input | 1 | Slow oscillator pulse, one clock wide |
| cpu_debug | input | 1 | Processor in debug halt |
| cpu_stop | input | 1 | Processor in stop mode |
| cpu_wait | input | 1 | Processor in wait mode |
| bus_wr | input | 1 | Bus write strobe |
| bus_sel | input | 2 | Target: 0 refresh key, 1 flag, 2 reset count |
| bus_wdata | input | 16 | Write data |
| wdog_rst_o | output | 1 | Reset request pulse |
| irq_o | output | 1 | Interrupt pulse at timeout |
| flag_o | output | 1 | Sticky interrupt flag |
| count_o | output | 32 | Live counter value |
| rst_count_o | output | 16 | Saturating count of watchdog resets |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, 3-bit divider, 16-bit keys, a 128-tick grace period and a 16-bit reset counter. Because timeout and window are ports, small programmed timeouts make the exact T*(P+1) timing checkable over many random pairs. The full grace period fits in a few hundred cycles. A timeout of one tick makes the watchdog reset on every cycle, which drives the 16-bit reset counter into saturation in about 65 thousand cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   typedef enum logic [1:0] {
      SEL_REFRESH = 2'd0,
      SEL_FLAG    = 2'd1,
      SEL_RSTCNT  = 2'd2,
      SEL_NONE    = 2'd3
   } wdt_sel_e;

   typedef enum logic {
      ST_RUN   = 1'b0,
      ST_GRACE = 1'b1
   } wdt_state_e;
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
   parameter int PRESC_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               src_bus,
   input  logic               lpo_tick,
   input  logic               run,
   input  logic [PRESC_W-1:0] presc,
   output logic               tick
);
   logic [PRESC_W-1:0] div_q;
   logic               src_tick;
   logic               wrap;

   if (PRESC_W < 1) begin : g_bad_presc
      $error("wdt_tick_gen: PRESC_W must be at least 1");
   end

   // source select: bus clock means every cycle is a source tick
   assign src_tick = src_bus ? 1'b1 : lpo_tick;
   assign wrap     = (div_q >= presc);
   assign tick     = run & src_tick & wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (clr) begin
         div_q <= '0;
      end else if (run && src_tick) begin
         div_q <= wrap ? '0 : div_q + 1'b1;
      end
   end
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq #(
   parameter int             KEY_W      = 16,
   parameter logic [KEY_W-1:0] KEY_FIRST  = 16'hA602,
   parameter logic [KEY_W-1:0] KEY_SECOND = 16'hB480
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr,
   input  logic [KEY_W-1:0] wdata,
   output logic             armed_o,
   output logic             refresh_ok_o,
   output logic             key_fault_o
);
   logic armed_q;

   if (KEY_FIRST == KEY_SECOND) begin : g_bad_keys
      $error("wdt_key_seq: the two key words must differ");
   end

   assign armed_o      = armed_q;
   assign refresh_ok_o = wr & armed_q & (wdata == KEY_SECOND);
   assign key_fault_o  = wr & armed_q & (wdata != KEY_SECOND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (clr) begin
         armed_q <= 1'b0;
      end else if (wr) begin
         // any write while armed completes the pair; idle waits for the first word
         armed_q <= !armed_q && (wdata == KEY_FIRST);
      end
   end
endmodule

// File: rtl/wdt_count_core.sv
module wdt_count_core
   import wdt_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int GRACE_TICKS = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             refresh_ok,
   input  logic             key_fault,
   input  logic             irq_en,
   input  logic             win_en,
   input  logic [CNT_W-1:0] timeout,
   input  logic [CNT_W-1:0] window,
   output logic [CNT_W-1:0] cnt_o,
   output logic             rst_o,
   output logic             irq_o,
   output logic             irq_set_o,
   output logic             in_grace_o,
   output logic             fire_o,
   output logic             clr_evt_o
);
   localparam int GW = (GRACE_TICKS > 1) ? $clog2(GRACE_TICKS) : 1;

   wdt_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             rst_q;
   logic             irq_q;
   logic             in_run;
   logic             reach;
   logic             win_early;
   logic             fault_req;
   logic             accept;
   logic             tmo;
   logic             grace_done;
   logic             fire;

   if (CNT_W < 2) begin : g_bad_cnt
      $error("wdt_count_core: CNT_W must be at least 2");
   end
   if (GRACE_TICKS < 1) begin : g_bad_grace
      $error("wdt_count_core: GRACE_TICKS must be at least 1");
   end

   assign in_run    = (state_q == ST_RUN);
   assign reach     = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, timeout};
   assign win_early = win_en & (cnt_q < window);
   assign fault_req = in_run & (key_fault | (refresh_ok & win_early));
   assign accept    = in_run & refresh_ok & !win_early;
   assign tmo       = in_run & tick & reach & !accept & !fault_req;
   assign fire      = fault_req | (tmo & !irq_en) | grace_done;

   if (GRACE_TICKS > 1) begin : g_grace_cnt
      logic [GW-1:0] gcnt_q;
      assign grace_done = !in_run & tick & (gcnt_q == GW'(GRACE_TICKS-1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            gcnt_q <= '0;
         end else if (in_run) begin
            gcnt_q <= '0;
         end else if (tick) begin
            gcnt_q <= gcnt_q + 1'b1;
         end
      end
   end else begin : g_grace_one
      assign grace_done = !in_run & tick;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         cnt_q   <= '0;
         rst_q   <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         rst_q <= fire;
         irq_q <= tmo & irq_en;
         if (fire) begin
            cnt_q   <= '0;
            state_q <= ST_RUN;
         end else if (accept) begin
            cnt_q <= '0;
         end else if (tmo && irq_en) begin
            state_q <= ST_GRACE;
         end else if (in_run && tick) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign cnt_o      = cnt_q;
   assign rst_o      = rst_q;
   assign irq_o      = irq_q;
   assign irq_set_o  = tmo & irq_en;
   assign in_grace_o = !in_run;
   assign fire_o     = fire;
   assign clr_evt_o  = fire | accept;

   // R1: an accepted key pair leaves the counter at zero
   a_r1_refresh_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (in_run && refresh_ok && !win_early) |=> (cnt_q == '0));

   // R6: the interrupt pulse only appears once the grace period has begun
   a_r6_irq_in_grace: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> (state_q == ST_GRACE));

   // R9: without a tick or a clearing event the count holds
   a_r9_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !fire && !accept) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_window_core.sv
module wdt_window_core
   import wdt_pkg::*;
#(
   parameter int               CNT_W       = 32,
   parameter int               PRESC_W     = 3,
   parameter int               KEY_W       = 16,
   parameter int               RCNT_W      = 16,
   parameter int               GRACE_TICKS = 128,
   parameter logic [KEY_W-1:0] KEY_FIRST   = 16'hA602,
   parameter logic [KEY_W-1:0] KEY_SECOND  = 16'hB480
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_enable,
   input  logic               cfg_src_bus,
   input  logic [PRESC_W-1:0] cfg_presc,
   input  logic               cfg_irq_en,
   input  logic               cfg_win_en,
   input  logic               cfg_run_debug,
   input  logic               cfg_run_stop,
   input  logic               cfg_run_wait,
   input  logic [CNT_W-1:0]   cfg_timeout,
   input  logic [CNT_W-1:0]   cfg_window,
   input  logic               lpo_tick,
   input  logic               cpu_debug,
   input  logic               cpu_stop,
   input  logic               cpu_wait,
   input  logic               bus_wr,
   input  logic [1:0]         bus_sel,
   input  logic [KEY_W-1:0]   bus_wdata,
   output logic               wdog_rst_o,
   output logic               irq_o,
   output logic               flag_o,
   output logic [CNT_W-1:0]   count_o,
   output logic [RCNT_W-1:0]  rst_count_o
);
   localparam logic [RCNT_W-1:0] RCNT_MAX = {RCNT_W{1'b1}};

   logic run;
   logic tick;
   logic wr_key;
   logic wr_flag;
   logic wr_rcnt;
   logic armed;
   logic refresh_ok;
   logic key_fault;
   logic irq_set;
   logic in_grace;
   logic fire;
   logic clr_evt;
   logic flag_q;
   logic [RCNT_W-1:0] rcnt_q;

   if (RCNT_W > KEY_W) begin : g_bad_rcnt
      $error("wdt_window_core: RCNT_W must not exceed KEY_W");
   end

   // counting halts in any processor mode whose run bit is clear
   assign run = cfg_enable
              & ~(cpu_debug & ~cfg_run_debug)
              & ~(cpu_stop  & ~cfg_run_stop)
              & ~(cpu_wait  & ~cfg_run_wait);

   assign wr_key  = bus_wr & cfg_enable & (bus_sel == SEL_REFRESH);
   assign wr_flag = bus_wr & (bus_sel == SEL_FLAG) & bus_wdata[0];
   assign wr_rcnt = bus_wr & (bus_sel == SEL_RSTCNT) & (bus_wdata[RCNT_W-1:0] == RCNT_MAX);

   wdt_tick_gen #(.PRESC_W(PRESC_W)) i_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr_evt),
      .src_bus  (cfg_src_bus),
      .lpo_tick (lpo_tick),
      .run      (run),
      .presc    (cfg_presc),
      .tick     (tick)
   );

   wdt_key_seq #(.KEY_W(KEY_W), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) i_key (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr          (fire),
      .wr           (wr_key),
      .wdata        (bus_wdata),
      .armed_o      (armed),
      .refresh_ok_o (refresh_ok),
      .key_fault_o  (key_fault)
   );

   wdt_count_core #(.CNT_W(CNT_W), .GRACE_TICKS(GRACE_TICKS)) i_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .refresh_ok (refresh_ok),
      .key_fault  (key_fault),
      .irq_en     (cfg_irq_en),
      .win_en     (cfg_win_en),
      .timeout    (cfg_timeout),
      .window     (cfg_window),
      .cnt_o      (count_o),
      .rst_o      (wdog_rst_o),
      .irq_o      (irq_o),
      .irq_set_o  (irq_set),
      .in_grace_o (in_grace),
      .fire_o     (fire),
      .clr_evt_o  (clr_evt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (irq_set) begin
         flag_q <= 1'b1;
      end else if (wr_flag) begin
         flag_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rcnt_q <= '0;
      end else if (wr_rcnt) begin
         rcnt_q <= '0;
      end else if (wdog_rst_o && (rcnt_q != RCNT_MAX)) begin
         rcnt_q <= rcnt_q + 1'b1;
      end
   end

   assign flag_o      = flag_q;
   assign rst_count_o = rcnt_q;

   // R2: a mismatching second word after the first key resets next cycle
   a_r2_wrong_key_resets: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_key && armed && (bus_wdata != KEY_SECOND) && !in_grace) |=> wdog_rst_o);

   // R7: the interrupt pulse always comes with the flag raised
   a_r7_flag_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> flag_o);

   // R10: a saturated reset counter stays saturated until cleared
   a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      ((rst_count_o == RCNT_MAX) && !wr_rcnt) |=> (rst_count_o == RCNT_MAX));

   // R12: a disabled watchdog keeps its count
   a_r12_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_enable |=> $stable(count_o));
endmodule

// File: tb/test_wdt_window_core.sv
module test_wdt_window_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_enable = 1'b1, cfg_src_bus = 1'b1, cfg_irq_en = 1'b0, cfg_win_en = 1'b0;
   logic        cfg_run_debug = 1'b1, cfg_run_stop = 1'b1, cfg_run_wait = 1'b1;
   logic [2:0]  cfg_presc = 3'd0;
   logic [31:0] cfg_timeout = 32'd1000, cfg_window = 32'd0;
   logic        lpo_tick = 1'b0, cpu_debug = 1'b0, cpu_stop = 1'b0, cpu_wait = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_sel = 2'd3;
   logic [15:0] bus_wdata = 16'h0;
   logic        wdog_rst_o, irq_o, flag_o;
   logic [31:0] count_o;
   logic [15:0] rst_count_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   wdt_window_core i_wdt_window_core (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_src_bus(cfg_src_bus),
      .cfg_presc(cfg_presc), .cfg_irq_en(cfg_irq_en), .cfg_win_en(cfg_win_en),
      .cfg_run_debug(cfg_run_debug), .cfg_run_stop(cfg_run_stop), .cfg_run_wait(cfg_run_wait),
      .cfg_timeout(cfg_timeout), .cfg_window(cfg_window), .lpo_tick(lpo_tick),
      .cpu_debug(cpu_debug), .cpu_stop(cpu_stop), .cpu_wait(cpu_wait),
      .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
      .wdog_rst_o(wdog_rst_o), .irq_o(irq_o), .flag_o(flag_o),
      .count_o(count_o), .rst_count_o(rst_count_o)
   );

   function automatic int exp_delay(int t, int p);
      return t * (p + 1);
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [1:0] s, logic [15:0] d);
      bus_wr = 1'b1; bus_sel = s; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_sel = 2'd3;
   endtask

   task automatic refresh();
      wr(2'd0, 16'hA602);
      wr(2'd0, 16'hB480);
   endtask

   task automatic por();
      rst_n = 1'b0;
      cyc(2);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd41));
      @(negedge clk);
      por();
      // R11 reset state
      chk("R11 count", count_o, 0);
      chk("R11 rst", {31'd0, wdog_rst_o}, 0);
      chk("R11 irq+flag", {30'd0, irq_o, flag_o}, 0);
      chk("R11 rstcnt", {16'd0, rst_count_o}, 0);

      // R5 bus source counts every cycle, R1 refresh clears
      cyc(20);
      chk("R5 bus source", count_o, 20);
      refresh();
      chk("R1 refresh clear", count_o, 0);
      cyc(5);
      // R2 lone second word while idle is ignored
      wr(2'd0, 16'hB480);
      chk("R2 idle ignore rst", {31'd0, wdog_rst_o}, 0);
      chk("R2 idle ignore count", count_o, 6);
      wr(2'd0, 16'hA602);
      wr(2'd0, 16'h0000);
      chk("R2 wrong second word", {31'd0, wdog_rst_o}, 1);
      chk("R11 count cleared by wdog reset", count_o, 0);
      cyc(1);
      chk("R10 increment", {16'd0, rst_count_o}, 1);
      chk("R11 rst pulse ends", {31'd0, wdog_rst_o}, 0);

      // R3 and R4 random timeout and prescaler
      for (int i = 0; i < 12; i++) begin
         int t = int'($urandom_range(40, 3));
         int p = int'($urandom_range(7, 0));
         int d = exp_delay(t, p);
         cfg_timeout = t; cfg_presc = 3'(p);
         por();
         refresh();
         cyc(d - 1);
         chk($sformatf("R3 early t=%0d p=%0d", t, p), {31'd0, wdog_rst_o}, 0);
         cyc(1);
         chk($sformatf("R3 fire t=%0d p=%0d", t, p), {31'd0, wdog_rst_o}, 1);
      end

      // R4 directed divide by 4
      cfg_timeout = 1000; cfg_presc = 3'd3;
      por(); refresh(); cyc(20);
      chk("R4 divide by 4", count_o, 5);
      cfg_presc = 3'd0;

      // R5 slow source
      cfg_src_bus = 1'b0;
      por(); cyc(30);
      chk("R5 no lpo no count", count_o, 0);
      for (int k = 0; k < 4; k++) begin
         lpo_tick = 1'b1; cyc(1); lpo_tick = 1'b0; cyc(2);
      end
      chk("R5 lpo pulses", count_o, 4);
      cfg_src_bus = 1'b1;

      // R9 mode halts
      for (int m = 0; m < 3; m++) begin
         logic [31:0] c;
         por(); cyc(3);
         if (m == 0) begin cpu_debug = 1'b1; cfg_run_debug = 1'b0; end
         if (m == 1) begin cpu_stop  = 1'b1; cfg_run_stop  = 1'b0; end
         if (m == 2) begin cpu_wait  = 1'b1; cfg_run_wait  = 1'b0; end
         c = count_o;
         cyc(10);
         chk($sformatf("R9 halt mode %0d", m), count_o, c);
         cfg_run_debug = 1'b1; cfg_run_stop = 1'b1; cfg_run_wait = 1'b1;
         cyc(10);
         chk($sformatf("R9 run mode %0d", m), count_o, c + 10);
         cpu_debug = 1'b0; cpu_stop = 1'b0; cpu_wait = 1'b0;
      end

      // R6 and R7 interrupt then grace
      cfg_irq_en = 1'b1; cfg_timeout = 10;
      por(); refresh();
      cyc(9);
      chk("R6 no irq yet", {30'd0, irq_o, flag_o}, 0);
      cyc(1);
      chk("R6 irq pulse", {29'd0, irq_o, flag_o, wdog_rst_o}, 3'b110);
      cyc(1);
      chk("R6 irq one cycle", {30'd0, irq_o, flag_o}, 2'b01);
      wr(2'd1, 16'h0000);
      chk("R7 write zero keeps flag", {31'd0, flag_o}, 1);
      refresh();
      cyc(123);
      chk("R6 grace not over", {31'd0, wdog_rst_o}, 0);
      cyc(1);
      chk("R6 reset after grace", {31'd0, wdog_rst_o}, 1);
      wr(2'd1, 16'h0001);
      chk("R7 w1c clears flag", {31'd0, flag_o}, 0);
      cfg_irq_en = 1'b0; cfg_timeout = 1000;

      // R8 window mode
      cfg_win_en = 1'b1; cfg_window = 20;
      por(); cyc(30);
      refresh();
      chk("R8 late refresh ok rst", {31'd0, wdog_rst_o}, 0);
      chk("R8 late refresh ok count", count_o, 0);
      refresh();
      chk("R8 early refresh fault", {31'd0, wdog_rst_o}, 1);
      cfg_win_en = 1'b0;

      // R12 disabled
      cfg_enable = 1'b0;
      por(); cyc(10);
      chk("R12 no count", count_o, 0);
      wr(2'd0, 16'hA602); wr(2'd0, 16'h0000);
      chk("R12 keys ignored", {31'd0, wdog_rst_o}, 0);
      cfg_enable = 1'b1;

      // R10 saturation and clear
      cfg_timeout = 1;
      por(); cyc(65600);
      chk("R10 saturate", {16'd0, rst_count_o}, 32'hFFFF);
      cfg_enable = 1'b0; cyc(3);
      wr(2'd2, 16'h1234);
      chk("R10 other value ignored", {16'd0, rst_count_o}, 32'hFFFF);
      wr(2'd2, 16'hFFFF);
      chk("R10 clear", {16'd0, rst_count_o}, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule